// File: doc/BRIEF.md
# Hardware Breakpoint Address-Match Unit

This unit watches the program-counter fetch address of a small 8-bit controller with a 16-bit address space. When that address equals a programmed break address, it asks the system logic to enter a debug routine. The break address is split across two byte-wide registers. A control register holds a compare enable and a status bit. Writing a one to that status bit also forces a break from software.

A break is never taken in the middle of an instruction. A trigger first arms a pending state. The breakpoint request is then raised for one cycle at the next instruction-boundary strobe. From that cycle on the break is active: the watchdog-suspend output is held high and the unit refuses further triggers. A return-from-interrupt strobe ends the break.

The vector address for the injected interrupt is supplied continuously and depends on the monitor-mode input. The registers remain fully accessible while a break is pending or active.

Top module: `brk_unit`

## Requirements
- R1: After reset, all three registers read 0x00, compare is disabled, and bkpt and wdog_hold are low.
- R2: The register select codes are 0 for the high address byte, 1 for the low address byte and 2 for control. Written bytes read back at the same code. Control reads as bit 7 = compare enable, bit 6 = break status (set while a break is pending or active), and the other bits 0. Code 3 reads 0x00.
- R3: An address break is armed only in a cycle where cpu_fetch is 1 and both cpu_addr[15:8] and cpu_addr[7:0] equal the high and low registers. A cycle with one byte differing, or with cpu_fetch low, arms nothing.
- R4: With control bit 7 clear, a matching fetch arms no break.
- R5: A control write with bit 6 set arms a break whatever the value of bit 7. Bit 7 is loaded from the same write.
- R6: An armed break raises bkpt at the first insn_end strobe sampled at least one clock after arming. bkpt goes high in the cycle after that strobe and stays high for exactly one cycle. Before that strobe, bkpt and wdog_hold stay low.
- R7: While a break is pending or active, further matches, software requests and boundary strobes raise no second bkpt.
- R8: rti while the break is active returns the unit to idle: next cycle wdog_hold is low and status bit 6 reads 0. rti while idle or pending has no effect.
- R9: wdog_hold is high from the bkpt cycle until the cycle after the ending rti, and low otherwise.
- R10: vec_addr is 0xFFFC when mon_mode is 0 and 0xFEFC when mon_mode is 1.
- R11: Register writes and reads work unchanged while a break is pending or active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the unit |
| reg_sel | input | 2 | Register select: 0 high byte, 1 low byte, 2 control |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| cpu_addr | input | 16 | Internal address bus |
| cpu_fetch | input | 1 | The current bus address comes from the program counter |
| insn_end | input | 1 | Instruction-boundary strobe |
| rti | input | 1 | Return-from-interrupt strobe |
| mon_mode | input | 1 | Monitor mode selects the alternate vector |
| bkpt | output | 1 | One-cycle breakpoint request |
| vec_addr | output | 16 | Vector address for the injected interrupt |
| wdog_hold | output | 1 | Holds the watchdog suspended during a break |

## Verification
The bench targets several near misses, and a design that got any of them wrong would break on a wrong address:
- a fetch that differs in only one byte;
- a matching address seen on a non-fetch cycle;
- a matching fetch with compare disabled.

It also arms breaks without a boundary strobe and with a strobe in the same cycle as the trigger. An early or undeferred request would show up as bkpt firing before the strobe.

Re-triggers by match, by software and by repeated strobes during a break are applied. A unit that failed to lock out would emit extra pulses.

Finally, rti is driven while idle and while pending. A unit that decoded rti in every state would cancel a pending break, or would drop the watchdog hold at the wrong time.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2
  } brk_state_t;
endpackage

// File: rtl/brk_regs.sv
module brk_regs #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] reg_sel,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            brk_busy,
  output logic [DW-1:0]   reg_rdata,
  output logic [AW-1:0]   brk_addr,
  output logic            brk_en,
  output logic            sw_req
);
  localparam int NB      = AW / DW;
  localparam int EN_BIT  = DW - 1;
  localparam int ACT_BIT = DW - 2;
  localparam logic [SELW-1:0] CTRL_SEL = SELW'(NB);

  // One byte register per address byte; select code 0 is the most significant byte.
  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic [SELW-1:0] MY_SEL = SELW'(NB - 1 - b);
    logic          wr_en;
    logic [DW-1:0] byte_d;
    logic [DW-1:0] byte_q;

    assign wr_en = reg_wr && (reg_sel == MY_SEL);

    always_comb begin
      byte_d = byte_q;
      if (wr_en) byte_d = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign brk_addr[b*DW +: DW] = byte_q;
  end

  logic ctrl_wr;
  logic en_d;
  logic en_q;

  assign ctrl_wr = reg_wr && (reg_sel == CTRL_SEL);

  always_comb begin
    en_d = en_q;
    if (ctrl_wr) en_d = reg_wdata[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign brk_en = en_q;
  assign sw_req = ctrl_wr && reg_wdata[ACT_BIT];

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NB; i++) begin
      if (reg_sel == SELW'(i)) reg_rdata = brk_addr[(NB-1-i)*DW +: DW];
    end
    if (reg_sel == CTRL_SEL) begin
      reg_rdata[EN_BIT]  = en_q;
      reg_rdata[ACT_BIT] = brk_busy;
    end
  end
endmodule

// File: rtl/brk_match.sv
module brk_match #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] cpu_addr,
  input  logic [AW-1:0] brk_addr,
  input  logic          cpu_fetch,
  input  logic          brk_en,
  output logic          hit
);
  localparam int NB = AW / DW;

  logic [NB-1:0] byte_eq;

  // One byte-wide comparator per address byte.
  for (genvar b = 0; b < NB; b++) begin : g_cmp
    assign byte_eq[b] = (cpu_addr[b*DW +: DW] == brk_addr[b*DW +: DW]);
  end

  assign hit = brk_en && cpu_fetch && (&byte_eq);
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic sw_req,
  input  logic insn_end,
  input  logic rti,
  output logic bkpt,
  output logic busy,
  output logic hold
);
  brk_state_t st_d;
  brk_state_t st_q;
  logic       bk_d;
  logic       bk_q;

  always_comb begin
    st_d = st_q;
    bk_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (hit || sw_req) st_d = ST_PEND;
      ST_PEND: if (insn_end) begin
        st_d = ST_ACT;
        bk_d = 1'b1;
      end
      ST_ACT:  if (rti) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      bk_q <= 1'b0;
    end else begin
      st_q <= st_d;
      bk_q <= bk_d;
    end
  end

  assign bkpt = bk_q;
  assign busy = (st_q != ST_IDLE);
  assign hold = (st_q == ST_ACT);
endmodule

// File: rtl/brk_unit.sv
module brk_unit #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] VEC_NORM = 16'hFFFC,
  parameter logic [15:0] VEC_MON  = 16'hFEFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_fetch,
  input  logic          insn_end,
  input  logic          rti,
  input  logic          mon_mode,
  output logic          bkpt,
  output logic [15:0]   vec_addr,
  output logic          wdog_hold
);
  logic [AW-1:0] brk_addr;
  logic          brk_en;
  logic          sw_req;
  logic          hit;
  logic          busy;

  brk_regs #(.AW(AW), .DW(DW), .SELW(2)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .brk_busy(busy), .reg_rdata(reg_rdata),
    .brk_addr(brk_addr), .brk_en(brk_en), .sw_req(sw_req)
  );

  brk_match #(.AW(AW), .DW(DW)) u_match (
    .cpu_addr(cpu_addr), .brk_addr(brk_addr), .cpu_fetch(cpu_fetch),
    .brk_en(brk_en), .hit(hit)
  );

  brk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hit(hit), .sw_req(sw_req),
    .insn_end(insn_end), .rti(rti), .bkpt(bkpt), .busy(busy),
    .hold(wdog_hold)
  );

  assign vec_addr = mon_mode ? VEC_MON : VEC_NORM;
endmodule

// File: rtl/brk_chk.sv
module brk_chk (
  input logic clk,
  input logic rst_n,
  input logic bkpt,
  input logic wdog_hold,
  input logic insn_end,
  input logic rti
);
  // R6: the request lasts one cycle
  a_r6_bkpt_single: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt |=> !bkpt);

  // R6: the request follows a boundary strobe
  a_r6_bkpt_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt |-> $past(insn_end));

  // R9: the watchdog hold is on in the request cycle
  a_r9_hold_with_bkpt: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt |-> wdog_hold);

  // R7: each entry into a break comes with a request
  a_r7_entry_has_bkpt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_hold) |-> bkpt);

  // R8: rti ends an active break
  a_r8_rti_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_hold && rti) |=> !wdog_hold);

  // R9: the hold persists until rti
  a_r9_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_hold && !rti) |=> wdog_hold);
endmodule

bind brk_unit brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bkpt(bkpt), .wdog_hold(wdog_hold),
  .insn_end(insn_end), .rti(rti)
);

// File: tb/tb_brk_unit.sv
`timescale 1ns/1ps
module tb_brk_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] cpu_addr;
  logic        cpu_fetch;
  logic        insn_end;
  logic        rti;
  logic        mon_mode;
  logic        bkpt;
  logic [15:0] vec_addr;
  logic        wdog_hold;

  always #5 clk = ~clk;

  brk_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .cpu_fetch(cpu_fetch), .insn_end(insn_end), .rti(rti),
    .mon_mode(mon_mode), .bkpt(bkpt), .vec_addr(vec_addr),
    .wdog_hold(wdog_hold)
  );

  int total = 0;
  int bad   = 0;
  int pulses = 0;
  bit done  = 0;

  // Behavioural reference model
  logic [7:0] m_hi, m_lo;
  bit         m_en;
  int         m_phase;   // 0 idle, 1 waiting for boundary, 2 in break
  bit         m_bk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = 8'h00; m_lo = 8'h00; m_en = 0; m_phase = 0; m_bk = 0;
    end else begin
      bit trig;
      bit nbk;
      trig = (m_en && cpu_fetch && (cpu_addr == {m_hi, m_lo})) ||
             (reg_wr && reg_sel == 2'd2 && reg_wdata[6]);
      nbk = 0;
      if (m_phase == 0) begin
        if (trig) m_phase = 1;
      end else if (m_phase == 1) begin
        if (insn_end) begin m_phase = 2; nbk = 1; end
      end else begin
        if (rti) m_phase = 0;
      end
      if (reg_wr) begin
        if (reg_sel == 2'd0) m_hi = reg_wdata;
        else if (reg_sel == 2'd1) m_lo = reg_wdata;
        else if (reg_sel == 2'd2) m_en = reg_wdata[7];
      end
      m_bk = nbk;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [1:0] s);
    case (s)
      2'd0: return m_hi;
      2'd1: return m_lo;
      2'd2: return {m_en, (m_phase != 0), 6'b0};
      default: return 8'h00;
    endcase
  endfunction

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R6 model bkpt", {15'b0, bkpt}, {15'b0, m_bk});
      chk("R9 model wdog_hold", {15'b0, wdog_hold}, {15'b0, (m_phase == 2)});
      chk("R10 model vec_addr", vec_addr, mon_mode ? 16'hFEFC : 16'hFFFC);
      chk("R2 model rdata", {8'b0, reg_rdata}, {8'b0, model_rd(reg_sel)});
      if (bkpt) pulses++;
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s;
    @(negedge clk);
    d = reg_rdata;
    cyc();
  endtask

  task automatic fetch(input logic [15:0] a, input logic f, input logic ie);
    cpu_addr = a; cpu_fetch = f; insn_end = ie;
    cyc();
    cpu_fetch = 1'b0; insn_end = 1'b0;
  endtask

  task automatic strobe_end();
    insn_end = 1'b1; cyc(); insn_end = 1'b0;
  endtask

  task automatic strobe_rti();
    rti = 1'b1; cyc(); rti = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int p0;
    rst_n = 1'b0; reg_sel = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    cpu_addr = 16'h0000; cpu_fetch = 1'b0; insn_end = 1'b0; rti = 1'b0; mon_mode = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    rd(2'd0, v); chk("R1 hi reset", {8'b0, v}, 16'h00);
    rd(2'd1, v); chk("R1 lo reset", {8'b0, v}, 16'h00);
    rd(2'd2, v); chk("R1 ctrl reset", {8'b0, v}, 16'h00);
    chk("R1 bkpt reset", {15'b0, bkpt}, 16'h0);
    chk("R1 wdog reset", {15'b0, wdog_hold}, 16'h0);

    // R2 register access
    wr(2'd0, 8'h12); wr(2'd1, 8'h34); wr(2'd2, 8'h80);
    rd(2'd0, v); chk("R2 hi readback", {8'b0, v}, 16'h12);
    rd(2'd1, v); chk("R2 lo readback", {8'b0, v}, 16'h34);
    rd(2'd2, v); chk("R2 ctrl readback", {8'b0, v}, 16'h80);
    rd(2'd3, v); chk("R2 unused code", {8'b0, v}, 16'h00);

    // R3 near misses
    p0 = pulses;
    fetch(16'h1235, 1'b1, 1'b1);
    fetch(16'h1334, 1'b1, 1'b1);
    fetch(16'h1234, 1'b0, 1'b1);
    strobe_end(); cyc(2);
    chk("R3 near miss no pulse", 16'(pulses - p0), 16'd0);
    rd(2'd2, v); chk("R3 near miss status", {8'b0, v}, 16'h80);

    // R4 compare disabled
    wr(2'd2, 8'h00);
    fetch(16'h1234, 1'b1, 1'b0);
    strobe_end(); cyc(2);
    chk("R4 disabled no pulse", 16'(pulses - p0), 16'd0);
    rd(2'd2, v); chk("R4 disabled status", {8'b0, v}, 16'h00);

    // R3/R6 matching fetch, deferred to boundary
    wr(2'd2, 8'h80);
    fetch(16'h1234, 1'b1, 1'b0);
    cyc(3);
    chk("R6 no early pulse", 16'(pulses - p0), 16'd0);
    chk("R6 no early hold", {15'b0, wdog_hold}, 16'h0);
    rd(2'd2, v); chk("R3 pending status", {8'b0, v}, 16'hC0);
    insn_end = 1'b1; cyc(); insn_end = 1'b0;
    @(negedge clk);
    chk("R6 bkpt after boundary", {15'b0, bkpt}, 16'h1);
    chk("R9 hold with bkpt", {15'b0, wdog_hold}, 16'h1);
    cyc();
    @(negedge clk);
    chk("R6 bkpt one cycle", {15'b0, bkpt}, 16'h0);
    cyc();

    // R7 no retrigger; R11 registers during break
    fetch(16'h1234, 1'b1, 1'b1);
    wr(2'd2, 8'hC0);
    strobe_end(); strobe_end(); cyc(2);
    chk("R7 single pulse", 16'(pulses - p0), 16'd1);
    wr(2'd1, 8'h56);
    rd(2'd1, v); chk("R11 write during break", {8'b0, v}, 16'h56);
    chk("R9 hold during break", {15'b0, wdog_hold}, 16'h1);

    // R8 rti ends break
    rti = 1'b1; cyc(); rti = 1'b0;
    @(negedge clk);
    chk("R8 hold cleared", {15'b0, wdog_hold}, 16'h0);
    cyc();
    rd(2'd2, v); chk("R8 status cleared", {8'b0, v}, 16'h80);

    // R8 rti in idle and pending ignored; R5 software break with compare off
    strobe_rti();
    wr(2'd2, 8'h40);
    strobe_rti(); cyc();
    rd(2'd2, v); chk("R5 sw pending status", {8'b0, v}, 16'h40);
    strobe_end(); cyc();
    chk("R5 sw break pulse", 16'(pulses - p0), 16'd2);
    chk("R8 rti in pending ignored hold", {15'b0, wdog_hold}, 16'h1);
    strobe_rti(); cyc();

    // R6 trigger together with boundary strobe waits for next boundary
    wr(2'd2, 8'h80);
    fetch(16'h1256, 1'b1, 1'b1);
    @(negedge clk);
    chk("R6 same-cycle boundary no bkpt", {15'b0, bkpt}, 16'h0);
    cyc();
    strobe_end(); cyc();
    chk("R6 later boundary pulse", 16'(pulses - p0), 16'd3);
    strobe_rti(); cyc();

    // R10 vector selection
    mon_mode = 1'b0; @(negedge clk);
    chk("R10 normal vector", vec_addr, 16'hFFFC);
    cyc();
    mon_mode = 1'b1; @(negedge clk);
    chk("R10 monitor vector", vec_addr, 16'hFEFC);
    cyc(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule